// File: doc/BRIEF.md
# Four-Bit Lookahead ALU Slice with Operating-Mode Status

This combinational slice adds, subtracts, compares, shifts and applies bitwise logic to two 4-bit operands. Each bit cell forms its own propagate and generate terms at once. A separate lookahead unit turns those terms into the internal carries, with no ripple from bit to bit, and sends them back to the cells. The slice also exports group propagate and group generate, so a second-level lookahead unit can chain several slices. Each cell also has a one-bit Booth recoding path that gives a 2-bit signed partial product.

A 2-bit operating-mode input is decoded into two status levels, speed and efficiency. These are reported only and control no clock or supply. The lowest mode, sleep, also forces the arithmetic outputs to zero. A master enable releases every data output to high impedance, so several slices can share one result bus.

Top module: `cla_alu_slice`

## Requirements
- R1: While `en` is 0, `result`, `carry_out`, `grp_prop`, `grp_gen` and `booth_pp` are all high impedance, and `speed_lvl` and `eff_lvl` stay driven.
- R2: Opcode 0000 (add): {`carry_out`,`result`} equals `a_in` + `b_in` + `carry_in`.
- R3: Opcode 0001 (subtract): `result` equals (`a_in` - `b_in`) mod 16, `carry_in` is ignored, and `carry_out` is 1 exactly when `a_in` >= `b_in` (unsigned).
- R4: Opcodes 0010, 0011, 0100 and 0101 give `a_in` AND `b_in`, OR, XOR and NOT `a_in` respectively, with `carry_out` 0.
- R5: Opcode 0110 gives `a_in` shifted left by one with 0 entering bit 0. Opcode 0111 gives `a_in` shifted right by one with 0 entering bit 3. In both cases `carry_out` is 0.
- R6: Opcode 1000 (unsigned set-less-than): `result` is 0001 when `a_in` < `b_in` and 0000 otherwise, and `carry_out` is 0.
- R7: Opcode 1001 (Booth product): for each bit i, with b[-1] taken as 0, `booth_pp[2i+1:2i]` is 01 when a[i]=1, b[i]=0 and b[i-1]=1; it is 11 when a[i]=1, b[i]=1 and b[i-1]=0; otherwise it is 00. `result[i]` equals `booth_pp[2i]` and `carry_out` is 0. Under every other opcode `booth_pp` is zero.
- R8: Opcodes 1010 to 1111 give `result` 0000 and `carry_out` 0.
- R9: `grp_prop` is the AND of (a[i] XOR b'[i]) and `grp_gen` is bit 4 of `a_in` + b', where b' is NOT `b_in` for opcodes 0001 and 1000 and `b_in` for all other opcodes.
- R10: `pwr_mode` 00 (turbo) gives speed/efficiency 11/00, 01 (balanced) gives 10/01, 10 (low-power) gives 01/10, and 11 (sleep) gives 00/11.
- R11: In sleep mode with `en` high, `result`, `carry_out` and `booth_pp` are zero, while `grp_prop` and `grp_gen` still follow R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4 | First operand |
| b_in | input | 4 | Second operand |
| carry_in | input | 1 | Carry into bit 0, used by add only |
| op_sel | input | 4 | Operation code |
| en | input | 1 | Master enable; when low, data outputs float |
| pwr_mode | input | 2 | Operating-mode select |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Carry from bit 3 for add and subtract |
| grp_prop | output | 1 | Group propagate for a second lookahead level |
| grp_gen | output | 1 | Group generate for a second lookahead level |
| booth_pp | output | 8 | Per-bit 2-bit Booth partial products |
| speed_lvl | output | 2 | Decoded speed status |
| eff_lvl | output | 2 | Decoded efficiency status |

## Verification
The bench builds the slice at its default width of four bits. At that width the add, subtract, compare and Booth paths can be swept over all 256 operand pairs, and the add path under both carry-in values. This covers every carry chain the lookahead unit can form, including full propagation from carry-in to carry-out and the borrow boundary where `a_in` equals `b_in`. The enable, sleep and unused-opcode cases are then checked at the pins, including the floating state of the outputs.

// File: rtl/cla_alu_pkg.sv
package cla_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'h0,
        OP_SUB   = 4'h1,
        OP_AND   = 4'h2,
        OP_OR    = 4'h3,
        OP_XOR   = 4'h4,
        OP_NOTA  = 4'h5,
        OP_SHL   = 4'h6,
        OP_SHR   = 4'h7,
        OP_SLTU  = 4'h8,
        OP_BOOTH = 4'h9
    } alu_op_e;

    typedef enum logic [1:0] {
        MODE_TURBO = 2'b00,
        MODE_BAL   = 2'b01,
        MODE_LOWP  = 2'b10,
        MODE_SLEEP = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic [1:0] speed;
        logic [1:0] eff;
    } mode_status_t;

    // Subtract and compare both run the adder on the inverted second operand.
    function automatic logic op_inverts_b(input logic [3:0] op);
        return (op == OP_SUB) || (op == OP_SLTU);
    endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell
    import cla_alu_pkg::*;
(
    input  logic [3:0] op_sel,
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       b_lower,
    input  logic       a_lower,
    input  logic       a_upper,
    input  logic       carry_in,
    output logic       prop,
    output logic       gen,
    output logic       res_bit,
    output logic [1:0] pp
);

    logic b_eff_d;
    logic [1:0] pp_d;

    always_comb begin
        b_eff_d = b_bit ^ op_inverts_b(op_sel);
        prop    = a_bit ^ b_eff_d;
        gen     = a_bit & b_eff_d;

        // Radix-2 recoding of the pair (b[i], b[i-1]): 01 -> +a, 10 -> -a.
        pp_d = 2'b00;
        if (op_sel == OP_BOOTH && a_bit) begin
            case ({b_bit, b_lower})
                2'b01:   pp_d = 2'b01;
                2'b10:   pp_d = 2'b11;
                default: pp_d = 2'b00;
            endcase
        end
        pp = pp_d;

        case (op_sel)
            OP_ADD, OP_SUB: res_bit = prop ^ carry_in;
            OP_AND:         res_bit = a_bit & b_bit;
            OP_OR:          res_bit = a_bit | b_bit;
            OP_XOR:         res_bit = a_bit ^ b_bit;
            OP_NOTA:        res_bit = ~a_bit;
            OP_SHL:         res_bit = a_lower;
            OP_SHR:         res_bit = a_upper;
            OP_BOOTH:       res_bit = pp_d[0];
            default:        res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic             c0,
    output logic [WIDTH-1:0] carry,
    output logic             grp_p,
    output logic             grp_g,
    output logic             c_out
);

    always_comb begin
        logic term_d;
        logic prod_d;
        logic gg_d;
        // Every carry as a two-level sum of products over the bit terms.
        for (int i = 0; i < WIDTH; i++) begin
            term_d = c0;
            for (int k = 0; k < i; k++) term_d = term_d & prop[k];
            for (int j = 0; j < i; j++) begin
                prod_d = gen[j];
                for (int k = j + 1; k < i; k++) prod_d = prod_d & prop[k];
                term_d = term_d | prod_d;
            end
            carry[i] = term_d;
        end

        gg_d = 1'b0;
        for (int j = 0; j < WIDTH; j++) begin
            prod_d = gen[j];
            for (int k = j + 1; k < WIDTH; k++) prod_d = prod_d & prop[k];
            gg_d = gg_d | prod_d;
        end
        grp_g = gg_d;
        grp_p = &prop;
        c_out = gg_d | (grp_p & c0);
    end

endmodule

// File: rtl/mode_status_dec.sv
module mode_status_dec
    import cla_alu_pkg::*;
(
    input  logic [1:0]   pwr_mode,
    output mode_status_t status
);

    always_comb begin
        case (pwr_mode)
            MODE_TURBO: status = '{speed: 2'b11, eff: 2'b00};
            MODE_BAL:   status = '{speed: 2'b10, eff: 2'b01};
            MODE_LOWP:  status = '{speed: 2'b01, eff: 2'b10};
            default:    status = '{speed: 2'b00, eff: 2'b11};
        endcase
    end

endmodule

// File: rtl/cla_alu_slice.sv
module cla_alu_slice
    import cla_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   b_in,
    input  logic               carry_in,
    input  logic [3:0]         op_sel,
    input  logic               en,
    input  logic [1:0]         pwr_mode,
    output logic [WIDTH-1:0]   result,
    output logic               carry_out,
    output logic               grp_prop,
    output logic               grp_gen,
    output logic [2*WIDTH-1:0] booth_pp,
    output logic [1:0]         speed_lvl,
    output logic [1:0]         eff_lvl
);

    localparam int PP_W = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cout;
        logic [PP_W-1:0]  pp;
    } slice_out_t;

    logic [WIDTH-1:0] cell_p, cell_g, cell_res, la_carry;
    logic [PP_W-1:0]  cell_pp;
    logic             la_gp, la_gg, la_cout, c0_d;
    mode_status_t     status;
    slice_out_t       slice_d;

    always_comb begin
        if (op_inverts_b(op_sel))  c0_d = 1'b1;
        else if (op_sel == OP_ADD) c0_d = carry_in;
        else                       c0_d = 1'b0;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic a_lo, a_hi, b_lo;
        if (i == 0) begin : g_lsb
            assign a_lo = 1'b0;
            assign b_lo = 1'b0;
        end else begin : g_mid_lo
            assign a_lo = a_in[i-1];
            assign b_lo = b_in[i-1];
        end
        if (i == WIDTH - 1) begin : g_msb
            assign a_hi = 1'b0;
        end else begin : g_mid_hi
            assign a_hi = a_in[i+1];
        end

        cla_bit_cell u_cell (
            .op_sel  (op_sel),
            .a_bit   (a_in[i]),
            .b_bit   (b_in[i]),
            .b_lower (b_lo),
            .a_lower (a_lo),
            .a_upper (a_hi),
            .carry_in(la_carry[i]),
            .prop    (cell_p[i]),
            .gen     (cell_g[i]),
            .res_bit (cell_res[i]),
            .pp      (cell_pp[2*i+1:2*i])
        );
    end

    cla_lookahead #(.WIDTH(WIDTH)) u_lookahead (
        .prop (cell_p),
        .gen  (cell_g),
        .c0   (c0_d),
        .carry(la_carry),
        .grp_p(la_gp),
        .grp_g(la_gg),
        .c_out(la_cout)
    );

    mode_status_dec u_status (
        .pwr_mode(pwr_mode),
        .status  (status)
    );

    always_comb begin
        slice_d.res  = cell_res;
        slice_d.cout = 1'b0;
        slice_d.pp   = cell_pp;
        if (op_sel == OP_ADD || op_sel == OP_SUB) slice_d.cout = la_cout;
        if (op_sel == OP_SLTU) begin
            slice_d.res    = '0;
            slice_d.res[0] = ~la_cout;
        end
        if (pwr_mode == MODE_SLEEP) begin
            slice_d.res  = '0;
            slice_d.cout = 1'b0;
            slice_d.pp   = '0;
        end
    end

    assign result    = en ? slice_d.res  : {WIDTH{1'bz}};
    assign carry_out = en ? slice_d.cout : 1'bz;
    assign grp_prop  = en ? la_gp        : 1'bz;
    assign grp_gen   = en ? la_gg        : 1'bz;
    assign booth_pp  = en ? slice_d.pp   : {PP_W{1'bz}};
    assign speed_lvl = status.speed;
    assign eff_lvl   = status.eff;

    always_comb begin
        if (en === 1'b1 && pwr_mode != MODE_SLEEP && op_sel == OP_ADD)
            assert_add_sum_R2: assert ({carry_out, result} ==
                (WIDTH+1)'(a_in) + (WIDTH+1)'(b_in) + (WIDTH+1)'(carry_in))
                else $error("add mismatch");
    end

    always_comb begin
        if (en === 1'b1 && pwr_mode != MODE_SLEEP && op_sel == OP_SLTU)
            assert_sltu_R6: assert (result == WIDTH'(a_in < b_in))
                else $error("compare mismatch");
    end

    always_comb begin
        if (en === 1'b1 && pwr_mode != MODE_SLEEP && op_sel == OP_ADD && !carry_in)
            assert_group_gen_R9: assert (carry_out == grp_gen)
                else $error("group generate disagrees with carry");
    end

    always_comb begin
        assert_status_sum_R10: assert (({1'b0, speed_lvl} + {1'b0, eff_lvl}) == 3'd3)
            else $error("status levels inconsistent");
    end

    always_comb begin
        if (en === 1'b1 && pwr_mode == MODE_SLEEP)
            assert_sleep_zero_R11: assert (result == '0 && carry_out == 1'b0 && booth_pp == '0)
                else $error("sleep output not zero");
    end

endmodule

// File: tb/cla_alu_slice_tb.sv
module cla_alu_slice_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] a_in = '0, b_in = '0, op_sel = '0;
    logic       carry_in = 1'b0, en = 1'b0;
    logic [1:0] pwr_mode = 2'b00;
    logic [3:0] result;
    logic       carry_out, grp_prop, grp_gen;
    logic [7:0] booth_pp;
    logic [1:0] speed_lvl, eff_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_alu_slice u_dut (
        .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .op_sel(op_sel),
        .en(en), .pwr_mode(pwr_mode), .result(result), .carry_out(carry_out),
        .grp_prop(grp_prop), .grp_gen(grp_gen), .booth_pp(booth_pp),
        .speed_lvl(speed_lvl), .eff_lvl(eff_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic ci,
                         input logic [3:0] op, input logic e, input logic [1:0] m);
        @(negedge clk);
        a_in = a; b_in = b; carry_in = ci; op_sel = op; en = e; pwr_mode = m;
        #1;
    endtask

    task automatic chk_group(input string req, input int a, input int bp);
        chk(req, {31'd0, grp_gen}, 32'((a + bp) >> 4));
        chk(req, {31'd0, grp_prop}, {31'd0, &(4'(a) ^ 4'(bp))});
    endtask

    task automatic t_disabled;
        drive(4'hA, 4'h7, 1'b1, 4'h0, 1'b0, 2'b01);
        chk("R1 result", {28'd0, result}, {28'd0, 4'bzzzz});
        chk("R1 carry_out", {31'd0, carry_out}, {31'd0, 1'bz});
        chk("R1 grp_prop", {31'd0, grp_prop}, {31'd0, 1'bz});
        chk("R1 grp_gen", {31'd0, grp_gen}, {31'd0, 1'bz});
        chk("R1 booth_pp", {24'd0, booth_pp}, {24'd0, 8'bzzzzzzzz});
        chk("R1 status driven", {28'd0, speed_lvl, eff_lvl}, 32'h9);
    endtask

    task automatic t_add;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int ci = 0; ci < 2; ci++) begin
                    drive(4'(a), 4'(b), 1'(ci), 4'h0, 1'b1, 2'b00);
                    chk("R2 add", {27'd0, carry_out, result}, 32'(a + b + ci));
                    chk_group("R9 add group", a, b);
                end
    endtask

    task automatic t_sub;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                drive(4'(a), 4'(b), 1'((a + b) & 1), 4'h1, 1'b1, 2'b01);
                chk("R3 sub", {28'd0, result}, 32'((a - b) & 15));
                chk("R3 no-borrow", {31'd0, carry_out}, {31'd0, a >= b});
                chk_group("R9 sub group", a, (~b) & 15);
            end
    endtask

    task automatic t_logic;
        logic [3:0] av [4] = '{4'hC, 4'hA, 4'h0, 4'hF};
        logic [3:0] bv [4] = '{4'hA, 4'h5, 4'hF, 4'h3};
        for (int i = 0; i < 4; i++) begin
            drive(av[i], bv[i], 1'b1, 4'h2, 1'b1, 2'b00);
            chk("R4 and", {27'd0, carry_out, result}, {28'd0, av[i] & bv[i]});
            drive(av[i], bv[i], 1'b1, 4'h3, 1'b1, 2'b00);
            chk("R4 or", {27'd0, carry_out, result}, {28'd0, av[i] | bv[i]});
            drive(av[i], bv[i], 1'b1, 4'h4, 1'b1, 2'b00);
            chk("R4 xor", {27'd0, carry_out, result}, {28'd0, av[i] ^ bv[i]});
            chk_group("R9 logic group", int'(av[i]), int'(bv[i]));
            drive(av[i], bv[i], 1'b1, 4'h5, 1'b1, 2'b00);
            chk("R4 not", {27'd0, carry_out, result}, {28'd0, ~av[i]});
        end
    endtask

    task automatic t_shift;
        for (int a = 0; a < 16; a++) begin
            drive(4'(a), 4'h3, 1'b1, 4'h6, 1'b1, 2'b10);
            chk("R5 shl", {27'd0, carry_out, result}, 32'((a << 1) & 15));
            drive(4'(a), 4'h3, 1'b1, 4'h7, 1'b1, 2'b10);
            chk("R5 shr", {27'd0, carry_out, result}, 32'(a >> 1));
        end
    endtask

    task automatic t_sltu;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                drive(4'(a), 4'(b), 1'b0, 4'h8, 1'b1, 2'b00);
                chk("R6 sltu", {27'd0, carry_out, result}, {31'd0, a < b});
            end
    endtask

    task automatic t_booth;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                logic [7:0] epp;
                logic [3:0] eres;
                epp = '0; eres = '0;
                for (int i = 0; i < 4; i++) begin
                    logic bl;
                    bl = (i == 0) ? 1'b0 : b[i-1];
                    if (a[i] && !b[i] && bl)      epp[2*i +: 2] = 2'b01;
                    else if (a[i] && b[i] && !bl) epp[2*i +: 2] = 2'b11;
                    eres[i] = epp[2*i];
                end
                drive(4'(a), 4'(b), 1'b1, 4'h9, 1'b1, 2'b00);
                chk("R7 booth pp", {24'd0, booth_pp}, {24'd0, epp});
                chk("R7 booth res", {27'd0, carry_out, result}, {28'd0, eres});
            end
        drive(4'hF, 4'h2, 1'b0, 4'h0, 1'b1, 2'b00);
        chk("R7 pp zero off-op", {24'd0, booth_pp}, 32'd0);
    endtask

    task automatic t_unused;
        for (int op = 10; op < 16; op++) begin
            drive(4'hF, 4'hF, 1'b1, 4'(op), 1'b1, 2'b00);
            chk("R8 unused op", {27'd0, carry_out, result}, 32'd0);
        end
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            drive(4'h1, 4'h1, 1'b0, 4'h0, 1'b1, 2'(m));
            chk("R10 mode status", {28'd0, speed_lvl, eff_lvl}, 32'({2'(3 - m), 2'(m)}));
        end
    endtask

    task automatic t_sleep;
        drive(4'hF, 4'hF, 1'b1, 4'h0, 1'b1, 2'b11);
        chk("R11 sleep add", {27'd0, carry_out, result}, 32'd0);
        chk_group("R11 sleep group", 15, 15);
        drive(4'hF, 4'hE, 1'b0, 4'h9, 1'b1, 2'b11);
        chk("R11 sleep booth", {20'd0, booth_pp, result}, 32'd0);
        drive(4'h0, 4'h5, 1'b0, 4'h8, 1'b1, 2'b11);
        chk("R11 sleep sltu", {27'd0, carry_out, result}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_disabled();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_sltu();
        t_booth();
        t_unused();
        t_modes();
        t_sleep();
        t_disabled();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule